// File: doc/BRIEF.md
# H-Bridge Fault Protection Supervisor

This block decides, on every clock, whether the four power switches of an H-bridge may be driven. It samples digital flags from external comparators: one overcurrent flag per switch, an overtemperature flag, a pair of undervoltage flags and a pair of overvoltage flags. Each pair has one flag for entering the lockout and one for leaving it, so the comparator thresholds give hysteresis. It also accepts a commanded operating mode made of two independent enables: bridge run and regulator on.

Each fault class recovers in its own way. Overcurrent must persist through a deglitch window. It then forces a timed off period, after which the bridge comes back by itself. Overtemperature and overvoltage release when their comparator flags clear. Undervoltage is the only fault that also requests a reset of the internal logic. A commanded mode is accepted only after the current mode has been held for a minimum time. A sticky overcurrent flag lets the host see trips that recovered on their own, and a one-cycle strobe clears it.

Top module: `bridge_guard`

## Requirements
- R1: While reset is asserted, and until the first undervoltage release, the outputs are as follows: `bridge_en`=0, `ldo_en`=0, `logic_rst`=1, `oc_seen`=0, `fault_status`=4'b0001 and `fault_cause`=1.
- R2: A high `uv_fall_det` at a clock edge sets the undervoltage lockout from the next cycle, and only a high `uv_rise_ok` releases it. If both are high, the set wins. `logic_rst` equals the lockout state.
- R3: While the undervoltage lockout is active, the accepted mode is forced to off and the mode hold timer restarts. The sticky overcurrent flag and both overcurrent counters are cleared.
- R4: A high `ov_rise_det` locks the bridge off from the next cycle until a high `ov_fall_ok` is seen. Overvoltage does not reset the accepted mode, the sticky flag or `logic_rst`.
- R5: `ot_flag` is registered once. The bridge is off for every cycle in which the registered copy is high, and it drives again with no other action once the copy is low.
- R6: An overcurrent trip needs the OR of all `oc_flag` bits to be high on DEGLITCH_CYC consecutive clock edges. A run of one edge fewer is ignored, and every bit has the same effect.
- R7: After a trip the bridge stays off for exactly RETRY_CYC cycles and then re-enables by itself.
- R8: While the accepted mode has run=0 or undervoltage is locked, the deglitch count and the retry timer are held cleared. A pending retry is aborted.
- R9: `oc_seen` goes to 1 in the cycle after a trip. It goes to 0 after a cycle in which `oc_clr` is high and no trip occurs. A trip in the same cycle as `oc_clr` wins.
- R10: A request on `run_req`/`ldo_req` that differs from the accepted mode is taken only after the accepted mode has been held HOLD_CYC cycles. The hold count restarts at 0 each time a mode is accepted.
- R11: `ldo_en` follows the accepted regulator bit, is independent of the run bit and of all faults except undervoltage, and is 0 while undervoltage is locked.
- R12: `fault_status` bit 0 is undervoltage, bit 1 overvoltage, bit 2 overtemperature and bit 3 overcurrent retry, and all active causes are shown together. `fault_cause` encodes the highest-priority active cause: 1 undervoltage, 2 overvoltage, 3 overtemperature, 4 overcurrent, 0 none.
- R13: `bridge_en` is 1 exactly when the accepted run bit is 1 and no `fault_status` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oc_flag | input | NUM_FET | Per-switch overcurrent comparator flags |
| ot_flag | input | 1 | Die over-limit temperature flag |
| uv_fall_det | input | 1 | Supply below lower undervoltage threshold |
| uv_rise_ok | input | 1 | Supply above upper undervoltage threshold |
| ov_rise_det | input | 1 | Supply above upper overvoltage threshold |
| ov_fall_ok | input | 1 | Supply below lower overvoltage threshold |
| run_req | input | 1 | Requested bridge run (0 = sleep) |
| ldo_req | input | 1 | Requested regulator enable |
| oc_clr | input | 1 | Write-one-to-clear strobe for the sticky overcurrent flag |
| bridge_en | output | 1 | Bridge switches may be driven |
| ldo_en | output | 1 | Regulator enable |
| logic_rst | output | 1 | Synchronous internal logic reset request |
| fault_status | output | 4 | Active fault causes |
| fault_cause | output | 3 | Highest-priority active cause |
| oc_seen | output | 1 | Sticky overcurrent trip flag |

## Verification
On every cycle, the embedded assertions check these properties: the bridge is never driven while any status bit is set, a trip is always preceded by an asserted overcurrent flag, sleep and undervoltage clear a pending retry, a trip always sets the sticky flag, and a mode change happens only after the full hold time. Other behaviour can only be shown by the bench's scenarios against its cycle-level reference model. This covers the exact length of the retry window, short or interrupted overcurrent pulses being ignored, the set-wins rule of the clear strobe, the hysteresis of the two voltage lockouts, the cause priority when faults overlap, and the retained mode across an overvoltage event.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_UV   = 3'd1,
    CAUSE_OV   = 3'd2,
    CAUSE_OT   = 3'd3,
    CAUSE_OC   = 3'd4
  } cause_e;

  localparam int ST_W   = 4;
  localparam int ST_UV  = 0;
  localparam int ST_OV  = 1;
  localparam int ST_OT  = 2;
  localparam int ST_OC  = 3;
endpackage

// File: rtl/bg_hyst_latch.sv
module bg_hyst_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rel_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (set_i)      q_d = 1'b1;
    else if (rel_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R2 / R4: entering the lockout has priority over release
  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/bg_oc_guard.sv
module bg_oc_guard #(
  parameter int NUM_FET      = 4,
  parameter int DEGLITCH_CYC = 50,
  parameter int RETRY_CYC    = 200000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               wipe_i,
  input  logic [NUM_FET-1:0] oc_i,
  input  logic               oc_clr_i,
  output logic               retry_o,
  output logic               seen_o
);
  localparam int DG_W = $clog2(DEGLITCH_CYC + 1);
  localparam int RT_W = $clog2(RETRY_CYC + 1);
  localparam logic [DG_W-1:0] DG_LAST = DG_W'(DEGLITCH_CYC - 1);
  localparam logic [RT_W-1:0] RT_LAST = RT_W'(RETRY_CYC - 1);

  logic [DG_W-1:0] dg_d, dg_q;
  logic [RT_W-1:0] rt_d, rt_q;
  logic            retry_d, retry_q;
  logic            seen_d, seen_q;
  logic            trip;
  logic            any_oc;

  assign any_oc = |oc_i;

  always_comb begin
    dg_d    = dg_q;
    rt_d    = rt_q;
    retry_d = retry_q;
    trip    = 1'b0;
    if (flush_i) begin
      dg_d    = '0;
      rt_d    = '0;
      retry_d = 1'b0;
    end else if (retry_q) begin
      if (rt_q == RT_LAST) begin
        retry_d = 1'b0;
        rt_d    = '0;
      end else begin
        rt_d = rt_q + 1'b1;
      end
    end else if (any_oc) begin
      if (dg_q == DG_LAST) begin
        trip    = 1'b1;
        retry_d = 1'b1;
        dg_d    = '0;
        rt_d    = '0;
      end else begin
        dg_d = dg_q + 1'b1;
      end
    end else begin
      dg_d = '0;
    end
  end

  always_comb begin
    seen_d = seen_q;
    if (wipe_i)        seen_d = 1'b0;
    else if (trip)     seen_d = 1'b1;
    else if (oc_clr_i) seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dg_q    <= '0;
      rt_q    <= '0;
      retry_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      dg_q    <= dg_d;
      rt_q    <= rt_d;
      retry_q <= retry_d;
      seen_q  <= seen_d;
    end
  end

  assign retry_o = retry_q;
  assign seen_o  = seen_q;

  assert_trip_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_q) |-> $past(any_oc));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !retry_q);
  assert_trip_sets_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> seen_q);
endmodule

// File: rtl/bg_mode_gate.sv
module bg_mode_gate #(
  parameter int HOLD_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe_i,
  input  logic run_req_i,
  input  logic ldo_req_i,
  output logic run_o,
  output logic ldo_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);

  logic [1:0]    mode_d, mode_q, req;
  logic [HW-1:0] hold_d, hold_q;
  logic          held;

  assign req  = {run_req_i, ldo_req_i};
  assign held = (hold_q == HOLD_MAX);

  always_comb begin
    mode_d = mode_q;
    hold_d = hold_q;
    if (wipe_i) begin
      mode_d = 2'b00;
      hold_d = '0;
    end else if ((req != mode_q) && held) begin
      mode_d = req;
      hold_d = '0;
    end else if (!held) begin
      hold_d = hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      hold_q <= '0;
    end else begin
      mode_q <= mode_d;
      hold_q <= hold_d;
    end
  end

  assign run_o = mode_q[1];
  assign ldo_o = mode_q[0];

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != $past(mode_q)) && !$past(wipe_i)) |-> ($past(hold_q) == HOLD_MAX));
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import bg_pkg::*;
#(
  parameter int NUM_FET      = 4,
  parameter int DEGLITCH_CYC = 50,
  parameter int RETRY_CYC    = 200000,
  parameter int HOLD_CYC     = 50000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FET-1:0] oc_flag,
  input  logic               ot_flag,
  input  logic               uv_fall_det,
  input  logic               uv_rise_ok,
  input  logic               ov_rise_det,
  input  logic               ov_fall_ok,
  input  logic               run_req,
  input  logic               ldo_req,
  input  logic               oc_clr,
  output logic               bridge_en,
  output logic               ldo_en,
  output logic               logic_rst,
  output logic [ST_W-1:0]    fault_status,
  output logic [2:0]         fault_cause,
  output logic               oc_seen
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       uv_lock, ov_lock, ot_q;
  logic       oc_retry;
  logic       run_q, ldo_q;
  logic       oc_flush;
  cause_e     cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  bg_hyst_latch #(.RST_VAL(1'b1)) uv_latch_i (
    .clk(clk), .rst_n(rst_i_n), .set_i(uv_fall_det), .rel_i(uv_rise_ok), .q_o(uv_lock));

  bg_hyst_latch #(.RST_VAL(1'b0)) ov_latch_i (
    .clk(clk), .rst_n(rst_i_n), .set_i(ov_rise_det), .rel_i(ov_fall_ok), .q_o(ov_lock));

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ot_q <= 1'b0;
    else          ot_q <= ot_flag;
  end

  bg_mode_gate #(.HOLD_CYC(HOLD_CYC)) mode_i (
    .clk(clk), .rst_n(rst_i_n), .wipe_i(uv_lock),
    .run_req_i(run_req), .ldo_req_i(ldo_req),
    .run_o(run_q), .ldo_o(ldo_q));

  assign oc_flush = uv_lock | ~run_q;

  bg_oc_guard #(
    .NUM_FET(NUM_FET), .DEGLITCH_CYC(DEGLITCH_CYC), .RETRY_CYC(RETRY_CYC)
  ) oc_i (
    .clk(clk), .rst_n(rst_i_n), .flush_i(oc_flush), .wipe_i(uv_lock),
    .oc_i(oc_flag), .oc_clr_i(oc_clr), .retry_o(oc_retry), .seen_o(oc_seen));

  always_comb begin
    fault_status        = '0;
    fault_status[ST_UV] = uv_lock;
    fault_status[ST_OV] = ov_lock;
    fault_status[ST_OT] = ot_q;
    fault_status[ST_OC] = oc_retry;
  end

  always_comb begin
    if (uv_lock)       cause = CAUSE_UV;
    else if (ov_lock)  cause = CAUSE_OV;
    else if (ot_q)     cause = CAUSE_OT;
    else if (oc_retry) cause = CAUSE_OC;
    else               cause = CAUSE_NONE;
  end
  assign fault_cause = cause;

  assign bridge_en = run_q & ~uv_lock & ~ov_lock & ~ot_q & ~oc_retry;
  assign ldo_en    = ldo_q & ~uv_lock;
  assign logic_rst = uv_lock;

  assert_no_drive_on_fault_R13: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|fault_status) |-> !bridge_en);
  assert_uv_wipes_mode_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    logic_rst |=> (!run_q && !ldo_q && !oc_seen));
  assert_cause_matches_status_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((fault_status == '0) == (fault_cause == 3'd0)));
endmodule

// File: tb/bridge_guard_tb_top.sv
module bridge_guard_tb_top;
  localparam int NF   = 4;
  localparam int DG   = 5;
  localparam int RTY  = 40;
  localparam int HOLD = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] oc_flag;
  logic          ot_flag, uv_fall_det, uv_rise_ok, ov_rise_det, ov_fall_ok;
  logic          run_req, ldo_req, oc_clr;
  logic          bridge_en, ldo_en, logic_rst, oc_seen;
  logic [3:0]    fault_status;
  logic [2:0]    fault_cause;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit cmp_en = 1'b0;

  // reference model state
  int m_sync, m_uv, m_ov, m_ot, m_rty, m_dg, m_rc, m_seen, m_run, m_ldo, m_hold;

  always #10 clk = ~clk;

  bridge_guard #(.NUM_FET(NF), .DEGLITCH_CYC(DG), .RETRY_CYC(RTY), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .uv_fall_det(uv_fall_det), .uv_rise_ok(uv_rise_ok),
    .ov_rise_det(ov_rise_det), .ov_fall_ok(ov_fall_ok),
    .run_req(run_req), .ldo_req(ldo_req), .oc_clr(oc_clr),
    .bridge_en(bridge_en), .ldo_en(ldo_en), .logic_rst(logic_rst),
    .fault_status(fault_status), .fault_cause(fault_cause), .oc_seen(oc_seen));

  task automatic model_reset();
    m_uv = 1; m_ov = 0; m_ot = 0; m_rty = 0; m_dg = 0; m_rc = 0;
    m_seen = 0; m_run = 0; m_ldo = 0; m_hold = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int  n_uv, n_ov, n_rty, n_dg, n_rc, n_seen, n_run, n_ldo, n_hold;
      bit  trip, flush, anyoc;
      anyoc = (oc_flag != 0);
      flush = (m_uv == 1) || (m_run == 0);
      trip  = 0;
      n_rty = m_rty; n_dg = m_dg; n_rc = m_rc;
      if (flush) begin n_rty = 0; n_dg = 0; n_rc = 0; end
      else if (m_rty == 1) begin
        if (m_rc == RTY - 1) begin n_rty = 0; n_rc = 0; end else n_rc = m_rc + 1;
      end else if (anyoc) begin
        if (m_dg == DG - 1) begin trip = 1; n_rty = 1; n_dg = 0; n_rc = 0; end
        else n_dg = m_dg + 1;
      end else n_dg = 0;
      n_seen = m_seen;
      if (m_uv == 1) n_seen = 0; else if (trip) n_seen = 1; else if (oc_clr) n_seen = 0;
      n_run = m_run; n_ldo = m_ldo; n_hold = m_hold;
      if (m_uv == 1) begin n_run = 0; n_ldo = 0; n_hold = 0; end
      else if (((run_req != m_run) || (ldo_req != m_ldo)) && m_hold == HOLD) begin
        n_run = run_req; n_ldo = ldo_req; n_hold = 0;
      end else if (m_hold < HOLD) n_hold = m_hold + 1;
      n_uv = uv_fall_det ? 1 : (uv_rise_ok ? 0 : m_uv);
      n_ov = ov_rise_det ? 1 : (ov_fall_ok ? 0 : m_ov);
      m_ot = ot_flag;
      m_uv = n_uv; m_ov = n_ov; m_rty = n_rty; m_dg = n_dg; m_rc = n_rc;
      m_seen = n_seen; m_run = n_run; m_ldo = n_ldo; m_hold = n_hold;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    cyc++;
    if (cmp_en && rst_n) begin
      int e_cause;
      e_cause = m_uv ? 1 : m_ov ? 2 : m_ot ? 3 : m_rty ? 4 : 0;
      chk("R13 model bridge_en", bridge_en,
          (m_run && !m_uv && !m_ov && !m_ot && !m_rty) ? 1 : 0);
      chk("R12 model status", fault_status, m_rty*8 + m_ot*4 + m_ov*2 + m_uv);
      chk("R12 model cause", fault_cause, e_cause);
      chk("R2 model logic_rst", logic_rst, m_uv);
      chk("R11 model ldo_en", ldo_en, (m_ldo && !m_uv) ? 1 : 0);
      chk("R9 model oc_seen", oc_seen, m_seen);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_uv_rise();  uv_rise_ok = 1;  step(1); uv_rise_ok = 0;  endtask
  task automatic pulse_uv_fall();  uv_fall_det = 1; step(1); uv_fall_det = 0; endtask
  task automatic pulse_ov_rise();  ov_rise_det = 1; step(1); ov_rise_det = 0; endtask
  task automatic pulse_ov_fall();  ov_fall_ok = 1;  step(1); ov_fall_ok = 0;  endtask

  initial begin
    rst_n = 0; oc_flag = '0; ot_flag = 0; uv_fall_det = 0; uv_rise_ok = 0;
    ov_rise_det = 0; ov_fall_ok = 0; run_req = 0; ldo_req = 0; oc_clr = 0;
    step(3);
    cmp_en = 1;
    chk("R1 bridge_en", bridge_en, 0);
    chk("R1 ldo_en", ldo_en, 0);
    chk("R1 logic_rst", logic_rst, 1);
    chk("R1 status", fault_status, 1);
    chk("R1 cause", fault_cause, 1);
    chk("R1 oc_seen", oc_seen, 0);
    rst_n = 1;
    step(4);
    chk("R1 uv held after reset", logic_rst, 1);
    pulse_uv_rise();
    step(1);
    chk("R2 uv released", logic_rst, 0);

    run_req = 1; ldo_req = 1;
    step(2);
    chk("R10 not yet accepted", bridge_en, 0);
    step(HOLD + 2);
    chk("R13 bridge driving", bridge_en, 1);
    chk("R11 ldo on", ldo_en, 1);

    ldo_req = 0;
    step(2);
    chk("R10 change deferred", ldo_en, 1);
    step(HOLD + 2);
    chk("R11 ldo off", ldo_en, 0);
    chk("R11 bridge independent", bridge_en, 1);

    // R6: short and interrupted overcurrent runs are ignored
    oc_flag = 4'b0100; step(DG - 1); oc_flag = '0; step(2);
    chk("R6 short pulse ignored seen", oc_seen, 0);
    chk("R6 short pulse bridge", bridge_en, 1);
    oc_flag = 4'b0010; step(DG - 1); oc_flag = '0; step(1);
    oc_flag = 4'b0010; step(DG - 1); oc_flag = '0; step(2);
    chk("R6 interrupted pulse ignored", oc_seen, 0);

    // R6/R7: full run trips, retry window exact
    oc_flag = 4'b0001; step(DG);
    chk("R6 trip bridge off", bridge_en, 0);
    chk("R12 oc status bit", fault_status, 8);
    chk("R12 oc cause", fault_cause, 4);
    chk("R9 sticky set", oc_seen, 1);
    oc_flag = '0;
    step(RTY - 1);
    chk("R7 still off at window end", bridge_en, 0);
    step(1);
    chk("R7 auto re-enable", bridge_en, 1);

    oc_clr = 1; step(1); oc_clr = 0;
    chk("R9 w1c clears", oc_seen, 0);

    // R9: trip and clear together, trip from another switch
    oc_flag = 4'b1000; step(DG - 1); oc_clr = 1; step(1); oc_clr = 0; oc_flag = '0;
    chk("R9 set wins over clear", oc_seen, 1);
    chk("R6 other switch trips", bridge_en, 0);
    step(RTY + 2);
    oc_clr = 1; step(1); oc_clr = 0;

    // R8: sleep aborts a retry
    oc_flag = 4'b0010; step(DG); oc_flag = '0;
    run_req = 0; step(3);
    chk("R8 retry aborted by sleep", fault_status, 0);
    run_req = 1; step(HOLD + 3);
    chk("R8 no residual retry", bridge_en, 1);

    // R5 overtemperature
    ot_flag = 1; step(2);
    chk("R5 ot bridge off", bridge_en, 0);
    chk("R5 ot status", fault_status, 4);
    ot_flag = 0; step(2);
    chk("R5 ot recovers", bridge_en, 1);

    // R4 overvoltage with hysteresis, mode kept
    pulse_ov_rise(); step(3);
    chk("R4 ov latched", fault_status, 2);
    chk("R4 no logic reset", logic_rst, 0);
    chk("R4 bridge off", bridge_en, 0);
    pulse_ov_fall(); step(1);
    chk("R4 ov released, mode kept", bridge_en, 1);

    // R12 priority and R3 undervoltage wipe
    oc_flag = 4'b0100; step(DG); oc_flag = '0; step(RTY + 2);
    chk("R9 sticky before uv", oc_seen, 1);
    ot_flag = 1; pulse_ov_rise(); step(1);
    chk("R12 ov over ot", fault_cause, 2);
    chk("R12 both shown", fault_status, 6);
    pulse_uv_fall(); step(1);
    chk("R12 uv highest", fault_cause, 1);
    chk("R12 all shown", fault_status, 7);
    chk("R2 logic_rst on", logic_rst, 1);
    chk("R3 sticky wiped", oc_seen, 0);
    chk("R11 ldo off in uv", ldo_en, 0);
    step(4);
    chk("R2 hysteresis holds", logic_rst, 1);
    ot_flag = 0; pulse_ov_fall(); pulse_uv_rise(); step(2);
    chk("R3 mode reset after uv", bridge_en, 0);
    step(HOLD + 2);
    chk("R3 bridge back after hold", bridge_en, 1);

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule